// File: doc/BRIEF.md
# Dual I/O Serial Flash Burst Reader

This block lets on-chip logic fetch a run of bytes from a serial NOR flash with the dual I/O fast read command. A single-cycle start request carries a start address, a byte count and a flag that selects 3-byte or 4-byte addressing. The controller then owns the flash pins until the burst ends. It lowers chip select and sends the 0xBB command on one pin. It sends the address two bits per serial clock on both pins, then four clocks of mode bits. It releases both pins and shifts the returned data in two bits per clock.

The serial clock is the system clock divided by an even factor. Outgoing bits change only while the serial clock is low, on its falling transitions. Incoming bits are captured on its rising transitions. The idle level of the serial clock, low or high, is chosen by an input, so both SPI mode 0 and mode 3 are covered. Every assembled byte is presented with a one-cycle valid strobe. When the last byte is in, chip select rises, done pulses for one cycle and busy drops.

Top module: `dio_flash_reader`

## Requirements
- R1: Each burst starts with the command byte 0xBB, sent MSB first over the first 8 serial clocks on io0 only. io0_oe is high and io1_oe is low during these clocks.
- R2: The address follows the command two bits per clock, highest pair first. io1 carries the higher (odd) bit of each pair and io0 the lower (even) bit. With addr4=1 all 32 bits of start_addr go out over 16 clocks. With addr4=0 only start_addr[23:0] goes out, over 12 clocks.
- R3: After the address, four clocks drive 1 on both pins with both output enables high, so the mode byte is 0xFF.
- R4: Both output enables fall during the high phase of the last mode clock and stay low for the whole data phase, including every byte_vld cycle.
- R5: Data is captured on rising serial clock edges, two bits per clock, MSB first. io1 supplies bits 7,5,3,1 and io0 supplies bits 6,4,2,0. byte_vld is high for exactly one system cycle per byte, with that byte on rd_data.
- R6: While chip select is low, the serial clock has exactly 8 + A + 4 + 4·N rising edges, where A is 16 or 12 and N is the byte count. The returned bytes belong to consecutive flash addresses.
- R7: A byte_cnt of 0 requests 2^CNT_W bytes (256 with the default width).
- R8: The serial clock period is CLK_DIV system cycles, split into equal halves. io0_o and io1_o hold steady while the serial clock is high during a burst.
- R9: While chip select is high, sck equals sck_idle_hi.
- R10: In the cycle after the last data clock ends, cs_n goes high, busy goes low and done is high. done lasts exactly one cycle.
- R11: A start request while busy is high has no effect on the running burst. Its address, length and mode are not used.
- R12: After reset, cs_n=1, busy=0, done=0, byte_vld=0 and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle burst request, taken only while idle |
| start_addr | input | 32 | First flash address of the burst |
| byte_cnt | input | CNT_W | Number of bytes; 0 means 2^CNT_W |
| addr4 | input | 1 | 1 selects 32-bit addressing, 0 selects 24-bit |
| sck_idle_hi | input | 1 | Serial clock level while idle (0 for mode 0, 1 for mode 3) |
| byte_vld | output | 1 | One-cycle strobe for each received byte |
| rd_data | output | 8 | Received byte, valid with byte_vld |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse when a burst ends |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Flash serial clock |
| io0_o | output | 1 | Data out on pin 0 |
| io0_oe | output | 1 | Output enable for pin 0 |
| io0_i | input | 1 | Data in from pin 0 |
| io1_o | output | 1 | Data out on pin 1 |
| io1_oe | output | 1 | Output enable for pin 1 |
| io1_i | input | 1 | Data in from pin 1 |

## Verification
The hardest point to reach is the turnaround. It is the half clock where the last mode bit has been captured, the controller must already have let go of both pins, and the flash model puts the first data pair on the wire. The bench's flash model drives data from the falling edge that ends the last mode clock, and it counts any output enable it sees during data clocks. Every burst runs this check under both idle levels and both address widths. A start request is also injected in the middle of some bursts with a different address, length and width, to show that the burst in flight does not change. Directed runs cover the zero-count full burst and 24-bit address wrap.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam logic [7:0] RD_CMD      = 8'hBB;
    localparam int unsigned CMD_CLKS   = 8;
    localparam int unsigned MODE_CLKS  = 4;
    localparam int unsigned PAIRS_BYTE = 4;
    localparam int unsigned ADDR_CLKS_N = 12;
    localparam int unsigned ADDR_CLKS_W = 16;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [31:0] addr;
        logic        wide;
    } req_t;

    typedef struct packed {
        logic d1;
        logic d0;
        logic en1;
        logic en0;
    } pin_drv_t;

    function automatic int unsigned addr_clks(input logic wide);
        return wide ? ADDR_CLKS_W : ADDR_CLKS_N;
    endfunction

    // Pin values for one serial clock; rel counts clocks inside the phase.
    function automatic pin_drv_t pin_drive(input phase_e ph, input int unsigned rel,
                                           input logic [31:0] addr, input logic wide);
        pin_drv_t    p;
        int unsigned top;
        p = '0;
        case (ph)
            PH_CMD: begin
                p.d0  = RD_CMD[7 - (rel % 8)];
                p.en0 = 1'b1;
            end
            PH_ADDR: begin
                top   = (wide ? 31 : 23) - 2 * (rel % 16);
                p.d1  = addr[top % 32];
                p.d0  = addr[(top + 31) % 32];
                p.en0 = 1'b1;
                p.en1 = 1'b1;
            end
            PH_MODE: begin
                p = '1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dio_sck_gen.sv
module dio_sck_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic idle_hi,
    output logic sck,
    output logic phase_hi,
    output logic rise,
    output logic fall
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          hi;
    logic          tick;

    assign tick     = run && (cnt == LAST);
    assign rise     = tick && !hi;
    assign fall     = tick && hi;
    assign phase_hi = hi;
    assign sck      = run ? hi : idle_hi;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (run) begin
            if (cnt == LAST) begin
                cnt <= '0;
                hi  <= ~hi;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dio_seq.sv
module dio_seq
    import dio_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      start_addr,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             addr4,
    input  logic             phase_hi,
    input  logic             rise,
    input  logic             fall,
    output logic             active,
    output logic             done,
    output logic             restart,
    output logic             sample,
    output pin_drv_t         drv
);
    localparam logic [IDX_W-1:0] CMD_END = IDX_W'(CMD_CLKS);

    req_t             req;
    logic [CNT_W:0]   nbytes;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] addr_end;
    logic [IDX_W-1:0] mode_end;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] rel;
    phase_e           ph;
    pin_drv_t         raw;

    assign restart  = start && !active;
    assign addr_end = CMD_END + IDX_W'(addr_clks(req.wide));
    assign mode_end = addr_end + IDX_W'(MODE_CLKS);
    assign last_idx = mode_end + IDX_W'({nbytes, 2'b00}) - 1'b1;

    always_comb begin
        if (idx < CMD_END) begin
            ph  = PH_CMD;
            rel = idx;
        end else if (idx < addr_end) begin
            ph  = PH_ADDR;
            rel = idx - CMD_END;
        end else if (idx < mode_end) begin
            ph  = PH_MODE;
            rel = idx - addr_end;
        end else begin
            ph  = PH_DATA;
            rel = idx - mode_end;
        end
    end

    assign raw = pin_drive(ph, int'(rel), req.addr, req.wide);

    // Release both pins once the last mode bit has been clocked in.
    always_comb begin
        drv = active ? raw : '0;
        if (ph == PH_MODE && rel == IDX_W'(MODE_CLKS - 1) && phase_hi) begin
            drv.en0 = 1'b0;
            drv.en1 = 1'b0;
        end
        if (!active) begin
            drv.en0 = 1'b0;
            drv.en1 = 1'b0;
        end
    end

    assign sample = active && rise && (ph == PH_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            idx    <= '0;
            req    <= '0;
            nbytes <= '0;
        end else begin
            done <= 1'b0;
            if (restart) begin
                active   <= 1'b1;
                idx      <= '0;
                req.addr <= start_addr;
                req.wide <= addr4;
                nbytes   <= (byte_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, byte_cnt};
            end else if (active && fall) begin
                if (idx == last_idx) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dio_rx_pack.sv
module dio_rx_pack
    import dio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample,
    input  logic       io1_i,
    input  logic       io0_i,
    output logic       vld,
    output logic [7:0] data
);
    localparam logic [1:0] LAST_PAIR = 2'(PAIRS_BYTE - 1);

    logic [5:0] sh;
    logic [1:0] pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            pair <= '0;
            vld  <= 1'b0;
            data <= '0;
        end else begin
            vld <= 1'b0;
            if (clear) begin
                pair <= '0;
            end else if (sample) begin
                sh   <= {sh[3:0], io1_i, io0_i};
                pair <= pair + 1'b1;
                if (pair == LAST_PAIR) begin
                    data <= {sh, io1_i, io0_i};
                    vld  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dio_flash_reader.sv
module dio_flash_reader
    import dio_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4,
    parameter int unsigned CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      start_addr,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             addr4,
    input  logic             sck_idle_hi,
    output logic             byte_vld,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             sck,
    output logic             io0_o,
    output logic             io0_oe,
    input  logic             io0_i,
    output logic             io1_o,
    output logic             io1_oe,
    input  logic             io1_i
);
    localparam int unsigned HALF     = CLK_DIV / 2;
    localparam int unsigned MAX_CLKS = CMD_CLKS + ADDR_CLKS_W + MODE_CLKS
                                     + PAIRS_BYTE * (2 ** CNT_W);
    localparam int unsigned IDX_W    = $clog2(MAX_CLKS + 1);

    logic     active, restart, phase_hi, rise, fall, sample;
    pin_drv_t drv;

    dio_sck_gen #(.HALF(HALF)) u_sck (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (active),
        .idle_hi  (sck_idle_hi),
        .sck      (sck),
        .phase_hi (phase_hi),
        .rise     (rise),
        .fall     (fall)
    );

    dio_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .byte_cnt   (byte_cnt),
        .addr4      (addr4),
        .phase_hi   (phase_hi),
        .rise       (rise),
        .fall       (fall),
        .active     (active),
        .done       (done),
        .restart    (restart),
        .sample     (sample),
        .drv        (drv)
    );

    dio_rx_pack u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (restart),
        .sample (sample),
        .io1_i  (io1_i),
        .io0_i  (io0_i),
        .vld    (byte_vld),
        .data   (rd_data)
    );

    assign busy   = active;
    assign cs_n   = !active;
    assign io0_o  = drv.d0;
    assign io1_o  = drv.d1;
    assign io0_oe = drv.en0;
    assign io1_oe = drv.en1;

endmodule

// File: rtl/dio_flash_reader_chk.sv
module dio_flash_reader_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic sck,
    input logic sck_idle_hi,
    input logic io0_o,
    input logic io0_oe,
    input logic io1_o,
    input logic io1_oe,
    input logic byte_vld
);
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && !io0_oe && !io1_oe)); // R12

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (sck == sck_idle_hi)); // R9

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && cs_n && $past(busy))); // R10

    AST_VLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> (!io0_oe && !io1_oe)); // R4

    AST_VLD_ONE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld); // R5

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && sck && $past(busy) && $past(sck)) |-> ($stable(io0_o) && $stable(io1_o))); // R8

endmodule

bind dio_flash_reader dio_flash_reader_chk u_chk (.*);

// File: tb/sim_dio_flash_reader.sv
module sim_dio_flash_reader;

    localparam int DIV = 4;
    localparam int CW  = 8;
    localparam int TCK = 8; // 125 MHz

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [31:0]   start_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic          addr4 = 1'b0;
    logic          sck_idle_hi = 1'b0;
    logic          byte_vld, busy, done, cs_n, sck;
    logic [7:0]    rd_data;
    logic          io0_o, io0_oe, io1_o, io1_oe;
    logic          io0_i = 1'b0, io1_i = 1'b0;

    always #(TCK / 2) clk = ~clk;

    dio_flash_reader #(.CLK_DIV(DIV), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .addr4(addr4), .sck_idle_hi(sck_idle_hi),
        .byte_vld(byte_vld), .rd_data(rd_data), .busy(busy), .done(done),
        .cs_n(cs_n), .sck(sck), .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i),
        .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(io1_i)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_at(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ {a[27:24], a[31:28]} ^ 8'hA5;
    endfunction

    // flash model state
    int          kr, ds, abits, fm_n, oe_err, per_err, hold_err, data_bad, rx_cnt;
    bit          fm_wide;
    logic [7:0]  cap_opc, cap_mode, first_bad_act, first_bad_exp;
    logic [31:0] cap_addr, exp_base;
    time         last_rise;

    function automatic logic [31:0] flash_addr(input logic [31:0] base, input int i, input bit wide);
        logic [31:0] a;
        a = base + 32'(i);
        return wide ? a : {8'h00, a[23:0]};
    endfunction

    always @(posedge sck) begin
        if (!cs_n) begin
            if (kr > 0 && ($time - last_rise) != time'(DIV * TCK)) per_err++;
            last_rise = $time;
            if (kr < 8) begin
                cap_opc = {cap_opc[6:0], io0_o};
                if (!io0_oe || io1_oe) oe_err++;
            end else if (kr < 8 + abits) begin
                cap_addr = {cap_addr[29:0], io1_o, io0_o};
                if (!io0_oe || !io1_oe) oe_err++;
            end else if (kr < ds) begin
                cap_mode = {cap_mode[5:0], io1_o, io0_o};
                if (kr < ds - 1 && (!io0_oe || !io1_oe)) oe_err++;
            end else begin
                if (io0_oe || io1_oe) oe_err++;
            end
            kr++;
        end
    end

    always @(negedge sck) begin
        if (!cs_n && kr >= ds) begin
            automatic int d = kr - ds;
            automatic int b = d / 4;
            automatic int p = d % 4;
            if (b < fm_n) begin
                automatic logic [7:0] v = mem_at(flash_addr(cap_addr, b, fm_wide));
                io1_i = v[7 - 2 * p];
                io0_i = v[6 - 2 * p];
            end
        end
    end

    // byte and pin-hold monitor, sampled away from the active edge
    logic p_sck = 1'b0, p_busy = 1'b0, p_io0 = 1'b0, p_io1 = 1'b0;
    always @(negedge clk) begin
        if (byte_vld) begin
            automatic logic [7:0] e = mem_at(flash_addr(exp_base, rx_cnt, fm_wide));
            if (rd_data !== e && data_bad == 0) begin
                first_bad_act = rd_data;
                first_bad_exp = e;
            end
            if (rd_data !== e) data_bad++;
            rx_cnt++;
        end
        if (busy && sck && p_busy && p_sck && (io0_o !== p_io0 || io1_o !== p_io1)) hold_err++;
        p_sck = sck; p_busy = busy; p_io0 = io0_o; p_io1 = io1_o;
    end

    task automatic xfer(input logic [31:0] a, input logic [CW-1:0] c, input bit wide,
                        input bit cpol, input bit poke);
        int w;
        @(negedge clk);
        sck_idle_hi = cpol;
        @(negedge clk);
        check(cs_n && sck == cpol, "R9", "idle sck level", sck, cpol);
        kr = 0; cap_opc = '0; cap_mode = '0; cap_addr = '0;
        oe_err = 0; per_err = 0; hold_err = 0; data_bad = 0; rx_cnt = 0;
        fm_wide = wide; abits = wide ? 16 : 12; ds = 12 + abits;
        fm_n = (c == 0) ? (1 << CW) : int'(c);
        exp_base = wide ? a : {8'h00, a[23:0]};
        start = 1'b1; start_addr = a; byte_cnt = c; addr4 = wide;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1; start_addr = ~a; byte_cnt = c + 8'd3; addr4 = ~wide;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(done && cs_n && !busy, "R10", "end state {done,cs_n,busy}",
              {done, cs_n, busy}, 3'b110);
        @(negedge clk);
        check(!done, "R10", "done width", done, 0);
        check(cap_opc == 8'hBB, "R1", "command byte", cap_opc, 8'hBB);
        check(cap_addr == exp_base, "R2", "address sent", cap_addr, exp_base);
        check(cap_mode == 8'hFF, "R3", "mode byte", cap_mode, 8'hFF);
        check(oe_err == 0, "R4", "output-enable errors", oe_err, 0);
        check(data_bad == 0, "R5", "first bad byte", first_bad_act, first_bad_exp);
        check(kr == ds + 4 * fm_n, "R6", "rising edges under cs", kr, ds + 4 * fm_n);
        check(rx_cnt == fm_n, "R6", "bytes received", rx_cnt, fm_n);
        check(per_err == 0 && hold_err == 0, "R8", "clock period/hold errors",
              per_err + hold_err, 0);
        if (c == 0) check(rx_cnt == 256, "R7", "zero count bytes", rx_cnt, 256);
        if (poke) check(rx_cnt == fm_n && cap_addr == exp_base, "R11",
                        "burst after ignored start", cap_addr, exp_base);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        automatic int seed_dummy = $urandom(32'h1F2E3D4C);
        if (seed_dummy == 0) seed_dummy = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && !busy && !done && !byte_vld && !io0_oe && !io1_oe, "R12",
              "reset outputs", {cs_n, busy, done, byte_vld, io0_oe, io1_oe}, 6'b100000);

        // directed corners
        xfer(32'h0012_3456, 8'd4, 1'b0, 1'b0, 1'b0);
        xfer(32'hA5FF_FFFE, 8'd5, 1'b0, 1'b1, 1'b0);      // 24-bit wrap, upper byte dropped
        xfer(32'hFFFF_FFFD, 8'd6, 1'b1, 1'b0, 1'b0);      // 32-bit wrap
        xfer(32'h8000_0100, 8'd1, 1'b1, 1'b1, 1'b0);      // single byte, mode 3
        xfer(32'h0000_4000, 8'd0, 1'b0, 1'b0, 1'b0);      // zero count -> 256 (R7)
        xfer(32'h0102_0304, 8'd7, 1'b1, 1'b0, 1'b1);      // start while busy (R11)
        xfer(32'h00AB_CDEF, 8'd3, 1'b0, 1'b1, 1'b1);

        for (int i = 0; i < 24; i++) begin
            automatic logic [31:0] ra = $urandom;
            automatic logic [CW-1:0] rc = CW'($urandom_range(1, 12));
            automatic bit rw = 1'($urandom);
            automatic bit rp = 1'($urandom);
            automatic bit rk = ($urandom_range(0, 3) == 0);
            xfer(ra, rc, rw, rp, rk);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule